// File: doc/BRIEF.md
# External Static Memory Strobe Sequencer

This block turns single-beat internal access requests into chip-select, address, byte-lane, read-strobe and write-strobe waveforms for an external asynchronous static memory bus. It runs on a clock at twice the bus rate, and a phase bit splits each bus period into a first half and a second half. The bus clock output is high in the first half and low in the second. Strobes can therefore be placed on half-period boundaries. A request is accepted through a valid/ready handshake. Each request carries an address, a chip-select index, a write flag, write data, a byte mask and a wait count. Completion is signalled by a one-cycle response pulse, which carries the captured data on reads.

One configuration bit chooses the read protocol for every chip select. In the standard protocol the read strobe waits for the second half of the first bus period, as the write strobe always does. In the early protocol the read strobe starts with the access. It also stays low across back-to-back reads. When a read directly follows a write, the sequencer adds one turnaround bus period with the new address and select driven and no strobe active. A data-float setting holds the bus idle for a number of whole bus periods after every read.

Top module: `extBusSeq`

## Requirements
- R1: While reset is held and after it is released with no request, every chip select, the read strobe, the write strobe and every byte-lane enable are high (inactive), the data output enable is 0, `reqReady` is 0 during reset and `rspValid` is 0.
- R2: `busClk` is 1 in the first-half slot and 0 in the second-half slot of each bus period. The first slot after reset is a second half. `reqReady` is only ever 1 in a second-half slot, and an accepted access drives the bus from the very next slot.
- R3: Throughout every slot of an access, including its first half and any turnaround period, exactly the selected chip select (bit `reqCs` of `busCsN`) is low and `busAddr` equals the request address. All chip selects are high outside accesses.
- R4: With the protocol bit at 0 (standard), a read holds `busRdN` high in the first half of its first bus period. It then holds it low continuously until the end of its last bus period.
- R5: A write holds `busWrN` high in the first half of its first bus period and low from then to the end of the access, in both protocols. It drives the write data with `busDataOe` = 1 for the whole access. Its lane enables `busLaneN` equal the inverted mask, where bit i covers data bits 8i+7..8i. A read drives all lane enables low during its active periods.
- R6: With the protocol bit at 1 (early), a read to any chip select drives `busRdN` low from the first slot of its active periods to the end of the access.
- R7: In early mode, reads to the same chip select accepted back to back keep `busRdN` low with no high slot between them.
- R8: In early mode, a read accepted in the last slot of a write first spends one extra bus period with its chip select and address driven and both strobes high. Its wait periods then follow in full.
- R9: No turnaround period is inserted for read after write in standard mode, for write after read, for two accesses of the same type, or for a read after a write when at least one idle bus period separates them.
- R10: An access with wait count W (0 to 7) keeps its strobe active for W+1 bus periods.
- R11: Read data on `busDataIn` is sampled at the clock edge that ends the last active slot. `rspValid` is then 1 for exactly the following slot, with that data on `rspData`. Writes complete with the same pulse.
- R12: After a read with float setting F > 0, the bus stays idle and `reqReady` stays 0 for F whole bus periods. A new access may start right after them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus rate |
| rstN | input | 1 | Active-low synchronous reset |
| cfgEarlyRead | input | 1 | 1 selects the early read protocol for all devices |
| cfgFloat | input | FLOAT_W | Idle bus periods after each read |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted when high together with reqValid |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | ADDR_W | Access address |
| reqCs | input | CS_W | Chip-select index |
| reqWdata | input | DATA_W | Write data |
| reqMask | input | LANES | Byte lanes written (1 = write lane) |
| reqWait | input | WAIT_W | Extra whole bus periods of strobe |
| busClk | output | 1 | Bus clock, high in first half |
| busCsN | output | NUM_CS | Active-low chip selects |
| busAddr | output | ADDR_W | External address |
| busRdN | output | 1 | Active-low read strobe |
| busWrN | output | 1 | Active-low write strobe |
| busLaneN | output | LANES | Active-low byte-lane enables |
| busDataOut | output | DATA_W | Write data to the bus |
| busDataOe | output | 1 | Output enable for busDataOut |
| busDataIn | input | DATA_W | Read data from the bus |
| rspValid | output | 1 | One-cycle completion pulse |
| rspData | output | DATA_W | Captured read data |

## Verification
The hardest situation to reach from the ports is the write-to-read turnaround. It needs a read presented in exactly the one second-half slot that ends a write, in early mode. The read must also have non-zero wait states, so that the turnaround and the wait periods are seen to add up. The stimulus keeps the next request valid with no gap behind each accepted one, so back-to-back pairs happen every time. An explicit idle gap, given in bus slots, produces the negative case in which no turnaround may appear. The same gapless driving gives the boundary between two early reads, where a strobe that rises for a single slot would break R7.

// File: rtl/extBusPkg.sv
package extBusPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TURN  = 2'd1,
    ST_ACT   = 2'd2,
    ST_FLOAT = 2'd3
  } seqStateT;

  // control-to-datapath strobes, one set per half-period slot
  typedef struct packed {
    logic load;      // latch request fields at this edge
    logic done;      // this edge ends the last active slot
    logic isWrite;   // current access is a write
    logic driveBus;  // chip select and address driven this slot
    logic lanesOn;   // byte lanes driven this slot
    logic rdOn;      // read strobe low this slot
    logic wrOn;      // write strobe low this slot
    logic dataOn;    // write data driven this slot
    logic clkHigh;   // first-half slot
  } busStrobeT;

endpackage

// File: rtl/extBusCtrl.sv
module extBusCtrl
  import extBusPkg::*;
#(
  parameter int WAIT_W  = 3,
  parameter int FLOAT_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgEarlyRead,
  input  logic [FLOAT_W-1:0] cfgFloat,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [WAIT_W-1:0]  reqWait,
  output logic               reqReady,
  output busStrobeT          strobe
);

  localparam int CNT_W = (WAIT_W > FLOAT_W) ? WAIT_W : FLOAT_W;

  seqStateT          stateQ, stateD;
  logic [CNT_W-1:0]  cntQ, cntD;
  logic [WAIT_W-1:0] waitQ, waitD;
  logic              wrQ, wrD;
  logic              phaseQ;

  logic accept;
  logic lastBeat;
  logic firstCycle;
  logic turnNeeded;
  logic floatAfter;
  logic cntZero;

  always_comb begin
    cntZero    = (cntQ == '0);
    floatAfter = !wrQ && (cfgFloat != '0);
    lastBeat   = phaseQ && (stateQ == ST_ACT) && cntZero;
    reqReady   = phaseQ && ((stateQ == ST_IDLE) ||
                            ((stateQ == ST_ACT) && cntZero && !floatAfter) ||
                            ((stateQ == ST_FLOAT) && cntZero));
    accept     = reqValid && reqReady;
    turnNeeded = cfgEarlyRead && !reqWrite && (stateQ == ST_ACT) && wrQ;
    firstCycle = (cntQ == CNT_W'(waitQ));
  end

  always_comb begin
    stateD = stateQ;
    cntD   = cntQ;
    waitD  = waitQ;
    wrD    = wrQ;
    if (accept) begin
      wrD   = reqWrite;
      waitD = reqWait;
      if (turnNeeded) begin
        stateD = ST_TURN;
        cntD   = '0;
      end else begin
        stateD = ST_ACT;
        cntD   = CNT_W'(reqWait);
      end
    end else if (phaseQ) begin
      unique case (stateQ)
        ST_TURN: begin
          stateD = ST_ACT;
          cntD   = CNT_W'(waitQ);
        end
        ST_ACT: begin
          if (cntZero) begin
            if (floatAfter) begin
              stateD = ST_FLOAT;
              cntD   = CNT_W'(cfgFloat) - CNT_W'(1);
            end else begin
              stateD = ST_IDLE;
            end
          end else begin
            cntD = cntQ - CNT_W'(1);
          end
        end
        ST_FLOAT: begin
          if (cntZero) stateD = ST_IDLE;
          else         cntD   = cntQ - CNT_W'(1);
        end
        default: stateD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      waitQ  <= '0;
      wrQ    <= 1'b0;
      phaseQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
      waitQ  <= waitD;
      wrQ    <= wrD;
      phaseQ <= !phaseQ;
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.load     = accept;
    strobe.done     = lastBeat;
    strobe.isWrite  = wrQ;
    strobe.clkHigh  = !phaseQ;
    strobe.driveBus = (stateQ == ST_TURN) || (stateQ == ST_ACT);
    strobe.lanesOn  = (stateQ == ST_ACT);
    strobe.rdOn     = (stateQ == ST_ACT) && !wrQ &&
                      (cfgEarlyRead || phaseQ || !firstCycle);
    strobe.wrOn     = (stateQ == ST_ACT) && wrQ && (phaseQ || !firstCycle);
    strobe.dataOn   = (stateQ == ST_ACT) && wrQ;
  end

  AST_ACCEPT_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> strobe.driveBus) else $error("accept not followed by bus drive"); // R2

  AST_STD_READ_LATE: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgEarlyRead && strobe.rdOn && !phaseQ) |-> $past(strobe.rdOn))
    else $error("standard read strobe began in first half"); // R4

  AST_TURN_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ((stateQ == ST_TURN) && !phaseQ) |-> $past(strobe.wrOn))
    else $error("turnaround without preceding write"); // R8

  AST_READY_SECOND_HALF: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !strobe.clkHigh) else $error("ready in first half"); // R2

endmodule

// File: rtl/extBusPath.sv
module extBusPath
  import extBusPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int NUM_CS = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  busStrobeT                 strobe,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [$clog2(NUM_CS)-1:0] reqCs,
  input  logic [DATA_W-1:0]         reqWdata,
  input  logic [DATA_W/8-1:0]       reqMask,
  input  logic [DATA_W-1:0]         busDataIn,
  output logic                      busClk,
  output logic [NUM_CS-1:0]         busCsN,
  output logic [ADDR_W-1:0]         busAddr,
  output logic                      busRdN,
  output logic                      busWrN,
  output logic [DATA_W/8-1:0]       busLaneN,
  output logic [DATA_W-1:0]         busDataOut,
  output logic                      busDataOe,
  output logic                      rspValid,
  output logic [DATA_W-1:0]         rspData
);

  localparam int CS_W  = $clog2(NUM_CS);
  localparam int LANES = DATA_W / 8;

  logic [ADDR_W-1:0] addrQ;
  logic [CS_W-1:0]   csQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  maskQ;
  logic              rspValidQ;
  logic [DATA_W-1:0] rspDataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      csQ    <= '0;
      wdataQ <= '0;
      maskQ  <= '0;
    end else if (strobe.load) begin
      addrQ  <= reqAddr;
      csQ    <= reqCs;
      wdataQ <= reqWdata;
      maskQ  <= reqMask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValidQ <= 1'b0;
      rspDataQ  <= '0;
    end else begin
      rspValidQ <= strobe.done;
      if (strobe.done && !strobe.isWrite) rspDataQ <= busDataIn;
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : gSel
    assign busCsN[i] = !(strobe.driveBus && (csQ == CS_W'(i)));
  end

  always_comb begin
    busClk     = strobe.clkHigh;
    busAddr    = addrQ;
    busRdN     = !strobe.rdOn;
    busWrN     = !strobe.wrOn;
    busDataOut = wdataQ;
    busDataOe  = strobe.dataOn;
    if (!strobe.lanesOn)     busLaneN = '1;
    else if (strobe.isWrite) busLaneN = ~maskQ;
    else                     busLaneN = '0;
    rspValid = rspValidQ;
    rspData  = rspDataQ;
  end

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~busCsN) <= 1) else $error("several chip selects low"); // R3

  AST_NO_STROBE_CLASH: assert property (@(posedge clk) disable iff (!rstN)
    !(!busRdN && !busWrN)) else $error("read and write strobes both low"); // R5

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid) else $error("response longer than one cycle"); // R11

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.driveBus && $past(strobe.driveBus) && !$past(strobe.load)) |-> $stable(busAddr))
    else $error("address moved inside an access"); // R3

endmodule

// File: rtl/extBusSeq.sv
module extBusSeq
  import extBusPkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 16,
  parameter int NUM_CS  = 8,
  parameter int WAIT_W  = 3,
  parameter int FLOAT_W = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgEarlyRead,
  input  logic [FLOAT_W-1:0]        cfgFloat,
  input  logic                      reqValid,
  output logic                      reqReady,
  input  logic                      reqWrite,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [$clog2(NUM_CS)-1:0] reqCs,
  input  logic [DATA_W-1:0]         reqWdata,
  input  logic [DATA_W/8-1:0]       reqMask,
  input  logic [WAIT_W-1:0]         reqWait,
  output logic                      busClk,
  output logic [NUM_CS-1:0]         busCsN,
  output logic [ADDR_W-1:0]         busAddr,
  output logic                      busRdN,
  output logic                      busWrN,
  output logic [DATA_W/8-1:0]       busLaneN,
  output logic [DATA_W-1:0]         busDataOut,
  output logic                      busDataOe,
  input  logic [DATA_W-1:0]         busDataIn,
  output logic                      rspValid,
  output logic [DATA_W-1:0]         rspData
);

  busStrobeT strobe;

  extBusCtrl #(
    .WAIT_W (WAIT_W),
    .FLOAT_W(FLOAT_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgEarlyRead(cfgEarlyRead),
    .cfgFloat    (cfgFloat),
    .reqValid    (reqValid),
    .reqWrite    (reqWrite),
    .reqWait     (reqWait),
    .reqReady    (reqReady),
    .strobe      (strobe)
  );

  extBusPath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .NUM_CS(NUM_CS)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqAddr   (reqAddr),
    .reqCs     (reqCs),
    .reqWdata  (reqWdata),
    .reqMask   (reqMask),
    .busDataIn (busDataIn),
    .busClk    (busClk),
    .busCsN    (busCsN),
    .busAddr   (busAddr),
    .busRdN    (busRdN),
    .busWrN    (busWrN),
    .busLaneN  (busLaneN),
    .busDataOut(busDataOut),
    .busDataOe (busDataOe),
    .rspValid  (rspValid),
    .rspData   (rspData)
  );

endmodule

// File: tb/extBusSeq_tb.sv
module extBusSeq_tb;

  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;
  localparam int NUM_CS = 8;
  localparam int CS_W   = 3;
  localparam int LANES  = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgEarlyRead = 1'b0;
  logic [1:0]        cfgFloat = 2'd0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic              reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [CS_W-1:0]   reqCs = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic [LANES-1:0]  reqMask = '0;
  logic [2:0]        reqWait = '0;
  logic              busClk;
  logic [NUM_CS-1:0] busCsN;
  logic [ADDR_W-1:0] busAddr;
  logic              busRdN, busWrN, busDataOe, rspValid;
  logic [LANES-1:0]  busLaneN;
  logic [DATA_W-1:0] busDataOut, busDataIn, rspData;

  always #2.5 clk = !clk;

  // external memory model: data is a function of the address
  assign busDataIn = busAddr[DATA_W-1:0] ^ 16'h5A3C;

  extBusSeq u_dut (
    .clk(clk), .rstN(rstN), .cfgEarlyRead(cfgEarlyRead), .cfgFloat(cfgFloat),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqCs(reqCs), .reqWdata(reqWdata), .reqMask(reqMask), .reqWait(reqWait),
    .busClk(busClk), .busCsN(busCsN), .busAddr(busAddr), .busRdN(busRdN),
    .busWrN(busWrN), .busLaneN(busLaneN), .busDataOut(busDataOut),
    .busDataOe(busDataOe), .busDataIn(busDataIn), .rspValid(rspValid), .rspData(rspData)
  );

  typedef struct {
    bit          wr;
    int unsigned addr;
    int unsigned cs;
    int unsigned wdata;
    int unsigned mask;
    int unsigned waits;
    int          gap;
    string       tag;
  } stimT;

  typedef struct {
    int          kind;   // 0 turnaround, 1 active, 2 float
    bit          drive;
    int unsigned cs;
    int unsigned addr;
    bit          rdN;
    bit          wrN;
    bit          oe;
    int unsigned data;
    int unsigned lanes;
    bit          cap;
    bit          wr;
    string       tag;
  } slotT;

  stimT stimQ[$];
  slotT expQ[$];

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit modelPhase = 1'b1;  // first slot after reset is a second half
  bit pendRsp = 1'b0;
  bit pendWr = 1'b0;
  int unsigned pendData = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint unsigned act, input longint unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic pushAccess(input stimT s, input bit turn);
    slotT e;
    if (turn) begin
      for (int h = 0; h < 2; h++) begin
        e = '{kind: 0, drive: 1, cs: s.cs, addr: s.addr, rdN: 1, wrN: 1, oe: 0,
              data: 0, lanes: 3, cap: 0, wr: 0, tag: "R8"};
        expQ.push_back(e);
      end
    end
    for (int c = 0; c <= int'(s.waits); c++) begin
      for (int h = 0; h < 2; h++) begin
        bit strobeLow;
        strobeLow = (h == 1) || (c > 0);
        e.kind  = 1;
        e.drive = 1;
        e.cs    = s.cs;
        e.addr  = s.addr;
        e.rdN   = !(!s.wr && (strobeLow || cfgEarlyRead));
        e.wrN   = !(s.wr && strobeLow);
        e.oe    = s.wr;
        e.data  = s.wdata;
        e.lanes = s.wr ? (~s.mask & 3) : 0;
        e.cap   = (c == int'(s.waits)) && (h == 1);
        e.wr    = s.wr;
        e.tag   = (c > 0) ? "R10" : s.tag;
        expQ.push_back(e);
      end
    end
    if (!s.wr) begin
      for (int f = 0; f < 2 * int'(cfgFloat); f++) begin
        e = '{kind: 2, drive: 0, cs: 0, addr: 0, rdN: 1, wrN: 1, oe: 0,
              data: 0, lanes: 3, cap: 0, wr: 0, tag: "R12"};
        expQ.push_back(e);
      end
    end
  endtask

  // per-slot reference model and comparison
  always @(negedge clk) begin
    if (rstN && !finished) begin
      slotT e;
      bit have, expReady, accept, turn;
      logic [NUM_CS-1:0] expCs;
      string idleTag;
      cyc++;
      if (cyc > 100000) begin
        chk(1'b0, "R2", "watchdog expired", cyc, 100000);
        finish();
      end
      have = (expQ.size() > 0);
      if (have) e = expQ[0];
      else e = '{kind: 2, drive: 0, cs: 0, addr: 0, rdN: 1, wrN: 1, oe: 0,
                 data: 0, lanes: 3, cap: 0, wr: 0, tag: "R3"};
      idleTag = have ? "R12" : "R3";
      expCs = '1;
      if (e.drive) expCs[e.cs] = 1'b0;
      expReady = modelPhase && (expQ.size() <= 1);

      chk(busCsN == expCs, e.drive ? "R3" : idleTag, "busCsN", busCsN, expCs);
      if (e.drive) chk(busAddr == e.addr[ADDR_W-1:0], "R3", "busAddr", busAddr, e.addr);
      chk(busRdN == e.rdN, e.drive ? e.tag : idleTag, "busRdN", busRdN, e.rdN);
      chk(busWrN == e.wrN, e.drive ? e.tag : idleTag, "busWrN", busWrN, e.wrN);
      chk(busDataOe == e.oe, "R5", "busDataOe", busDataOe, e.oe);
      if (e.oe) chk(busDataOut == e.data[DATA_W-1:0], "R5", "busDataOut", busDataOut, e.data);
      chk(busLaneN == e.lanes[LANES-1:0], "R5", "busLaneN", busLaneN, e.lanes);
      chk(busClk == !modelPhase, "R2", "busClk", busClk, !modelPhase);
      chk(reqReady == expReady, (have && e.kind == 2) ? "R12" : "R2", "reqReady", reqReady, expReady);
      chk(rspValid == pendRsp, "R11", "rspValid", rspValid, pendRsp);
      if (pendRsp && !pendWr)
        chk(rspData == pendData[DATA_W-1:0], "R11", "rspData", rspData, pendData);

      pendRsp  = have && e.cap;
      pendWr   = e.wr;
      pendData = (e.addr & 32'hFFFF) ^ 32'h5A3C;

      // drive next request
      reqValid = 1'b0;
      if (stimQ.size() > 0) begin
        if (stimQ[0].gap > 0) stimQ[0].gap = stimQ[0].gap - 1;
        else begin
          reqValid = 1'b1;
          reqWrite = stimQ[0].wr;
          reqAddr  = stimQ[0].addr[ADDR_W-1:0];
          reqCs    = stimQ[0].cs[CS_W-1:0];
          reqWdata = stimQ[0].wdata[DATA_W-1:0];
          reqMask  = stimQ[0].mask[LANES-1:0];
          reqWait  = stimQ[0].waits[2:0];
        end
      end
      accept = reqValid && expReady;
      turn = accept && cfgEarlyRead && !reqWrite && (expQ.size() == 1) &&
             (e.kind == 1) && e.wr;
      if (have) void'(expQ.pop_front());
      if (accept) begin
        pushAccess(stimQ[0], turn);
        void'(stimQ.pop_front());
      end
      modelPhase = !modelPhase;
    end
  end

  task automatic addStim(input bit wr, input int unsigned addr, input int unsigned cs,
                         input int unsigned waits, input int gap, input string tag);
    stimT s;
    s.wr = wr; s.addr = addr; s.cs = cs; s.wdata = (addr * 7 + 16'h1234) & 16'hFFFF;
    s.mask = (addr % 3) + 1; s.waits = waits; s.gap = gap; s.tag = tag;
    stimQ.push_back(s);
  endtask

  task automatic drain();
    wait (stimQ.size() == 0 && expQ.size() == 0);
    repeat (6) @(negedge clk);
  endtask

  task automatic setCfg(input bit early, input logic [1:0] fl);
    @(posedge clk);
    #1;
    cfgEarlyRead = early;
    cfgFloat = fl;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busCsN == '1, "R1", "reset busCsN", busCsN, '1);
    chk(busRdN && busWrN, "R1", "reset strobes", {busRdN, busWrN}, 2'b11);
    chk(busLaneN == '1 && !busDataOe, "R1", "reset lanes/oe", {busLaneN, busDataOe}, 3'b110);
    chk(!reqReady && !rspValid, "R1", "reset ready/rsp", {reqReady, rspValid}, 2'b00);
    #1 rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk(busCsN == '1 && busRdN && busWrN && !rspValid, "R1", "idle after reset",
        {busCsN, busRdN, busWrN, rspValid}, {8'hFF, 3'b110});

    // standard protocol
    setCfg(1'b0, 2'd0);
    addStim(0, 24'h000101, 1, 0, 0, "R4");
    addStim(0, 24'h0A0202, 3, 2, 3, "R4");
    addStim(1, 24'h000303, 2, 0, 2, "R5");
    addStim(1, 24'h000404, 6, 1, 1, "R5");
    addStim(0, 24'h000505, 6, 1, 0, "R9");
    addStim(0, 24'h000606, 7, 0, 5, "R4");
    drain();

    // early protocol
    setCfg(1'b1, 2'd0);
    addStim(0, 24'h100001, 0, 0, 2, "R6");
    addStim(0, 24'h100002, 5, 1, 3, "R6");
    addStim(0, 24'h100010, 4, 0, 2, "R7");
    addStim(0, 24'h100011, 4, 0, 0, "R7");
    addStim(0, 24'h100012, 4, 2, 0, "R7");
    addStim(1, 24'h100020, 2, 0, 3, "R5");
    addStim(0, 24'h100021, 2, 0, 0, "R8");
    addStim(1, 24'h100030, 1, 2, 3, "R5");
    addStim(0, 24'h100031, 3, 1, 0, "R8");
    addStim(1, 24'h100040, 1, 0, 0, "R9");
    addStim(1, 24'h100041, 1, 1, 0, "R9");
    addStim(0, 24'h100050, 1, 0, 4, "R9");
    drain();

    // early protocol with float
    setCfg(1'b1, 2'd2);
    addStim(0, 24'h200001, 2, 0, 2, "R12");
    addStim(0, 24'h200002, 2, 1, 0, "R12");
    addStim(1, 24'h200003, 3, 0, 0, "R9");
    addStim(0, 24'h200004, 3, 0, 0, "R8");
    drain();

    // standard protocol with float
    setCfg(1'b0, 2'd1);
    addStim(0, 24'h300001, 0, 3, 1, "R12");
    addStim(0, 24'h300002, 7, 0, 0, "R12");
    addStim(1, 24'h300003, 7, 7, 0, "R10");
    drain();

    finish();
  end

endmodule